// File: doc/BRIEF.md
# Write-Free Hard Error Classifier

This controller runs after a read whose SEC-DED check reported one correctable bit error in a block. The corrected block goes back to the requester one cycle after the read, whether or not a classification starts. In parallel, the controller decides whether the failing cell suffered a retention upset (soft) or endurance wear (hard). It makes that decision without writing the data back to check it. It uses two kinds of evidence: the direction of the flipped bit, and single-cell re-reads against an alternate sense reference. A configuration input selects the endurance failure model, and the model sets which evidence is gathered.

The re-reads leave through a valid/ready request channel and return one comparator beat per request. When wear is found, the controller sends a one-cycle mark request to a pointer-based repair unit. In the high-conductance wear model, it then sends a one-cycle RESET pulse request for that cell. The repair unit reports how many pointers the block already uses. When a mark would need more pointers than a block may hold, the block is flagged as retired and the mark is skipped. Each classification ends with a one-cycle done pulse that carries the soft/hard verdict.

Top module: `hard_err_classifier`

## Requirements
- R1: Every read beat (`rd_valid_i`) yields `rsp_valid_o` exactly one cycle later, with `rsp_data_o` equal to the corrected block given with it. This holds even while a classification is running.
- R2: A classification starts only on a read beat with `rd_ce_i` high while the controller is idle. Reports that arrive while a classification is running produce no re-read, mark, reset or done.
- R3: With `fail_type_i` = 0 (model A) or 2 (model C), a corrected bit of 0 is a flip from 0 to 1. For it, the controller raises `mark_valid_o` for the failing index 1 cycle after the report, then `done_o` with `done_hard_o`=1 2 cycles after the report. No re-read is made.
- R4: With `fail_type_i` = 2, or with the value 3 (which behaves as model C), a corrected bit of 1 gives a soft done 1 cycle after the report, with no re-read and no mark.
- R5: With `fail_type_i` = 0 and a corrected bit of 1, exactly one re-read is made of the failing index, with `rr_ref_o` = 2'b01 (low reference). A result above the reference gives a mark and a hard done; otherwise the done is soft.
- R6: With `fail_type_i` = 1 (model B), one re-read is made for each index set in both the corrected data and `arr_mask_i`, in ascending index order, each with `rr_ref_o` = 2'b10 (high reference).
- R7: In model B, each scanned cell whose result is above the reference is marked. On the next cycle it gets `rst_pulse_o` with the same index. The done is hard.
- R8: In model B, if no scanned cell is above the reference, the result depends on the corrected bit. A corrected bit of 0 gives a mark of the failing index with no reset pulse, and a hard done. A corrected bit of 1 gives a soft done.
- R9: Each mark uses one pointer, counted from `ptr_used_i` sampled at the start. A block holds at most 6 pointers. A mark that would need a seventh pointer raises `retired_o` instead of `mark_valid_o`, and no reset pulse follows it.
- R10: `done_o` is a one-cycle pulse. `rr_valid_o` stays high with a stable index until `rr_ready_i` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fail_type_i | input | 2 | Wear model: 0 = A, 1 = B, 2 or 3 = C |
| rd_valid_i | input | 1 | Read beat from the ECC decoder |
| rd_ce_i | input | 1 | Correctable single-bit error on this beat |
| rd_err_idx_i | input | 9 | Index of the corrected bit |
| rd_data_i | input | 512 | Corrected block |
| arr_mask_i | input | 512 | Bits mapped to the same cross-point array as the failing bit |
| ptr_used_i | input | 3 | Pointers already used in this block |
| rsp_valid_o | output | 1 | Corrected data returned to the requester |
| rsp_data_o | output | 512 | Corrected block for the requester |
| rr_valid_o | output | 1 | Re-read request |
| rr_ready_i | input | 1 | Re-read request accepted |
| rr_idx_o | output | 9 | Cell index to re-read |
| rr_ref_o | output | 2 | Sense reference: 00 normal, 01 low, 10 high |
| rr_res_valid_i | input | 1 | Comparator result beat |
| rr_res_above_i | input | 1 | Cell current exceeded the reference |
| mark_valid_o | output | 1 | Mark cell bad (one cycle) |
| mark_idx_o | output | 9 | Cell to mark |
| rst_pulse_o | output | 1 | Request a RESET pulse (one cycle) |
| rst_idx_o | output | 9 | Cell to reset |
| retired_o | output | 1 | Pointer budget exhausted; mark skipped |
| done_o | output | 1 | Classification finished (one cycle) |
| done_hard_o | output | 1 | Verdict with done: 1 hard, 0 soft |

## Verification
The response is due one cycle after each read beat and is sampled on the next falling edge. A mark on the direct path comes 1 cycle after the report and its done 2 cycles after; a direct soft verdict comes after 1 cycle. The bench measures these cycle counts against the report cycle. Paths with re-reads have variable length, because the bench model stalls `rr_ready_i` and returns each result one cycle after acceptance. For those paths the scoreboard holds the exact sequence of accepted re-reads, marks, retirements, resets and the final verdict, and compares each as it appears. Any event beyond the expected list is reported.

// File: rtl/hec_pkg.sv
package hec_pkg;
  typedef enum logic [1:0] {
    REF_NORM = 2'b00,
    REF_LOW  = 2'b01,
    REF_HIGH = 2'b10
  } sense_ref_t;

  typedef enum logic [1:0] {
    FT_A = 2'd0,
    FT_B = 2'd1,
    FT_C = 2'd2
  } wear_model_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_REQ,
    S_WAIT,
    S_MARK,
    S_RST,
    S_DONE
  } cls_state_t;
endpackage

// File: rtl/hec_rsp_reg.sv
module hec_rsp_reg #(
  parameter int W = 512
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= in_data_i;
    end
  end
endmodule

// File: rtl/hec_first_one.sv
module hec_first_one #(
  parameter int W = 512,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hec_ptr_budget.sv
module hec_ptr_budget #(
  parameter int MAX_PTR = 6,
  localparam int CW = $clog2(MAX_PTR + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          use_i,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (load_val_i > CW'(MAX_PTR)) ? CW'(MAX_PTR) : load_val_i;
    end else if (use_i && (cnt_q < CW'(MAX_PTR))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q >= CW'(MAX_PTR));

  // R9
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_PTR));

  // R9
  no_use_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && !load_i) |-> !full_o);
endmodule

// File: rtl/hard_err_classifier.sv
module hard_err_classifier
  import hec_pkg::*;
#(
  parameter int BLK_W   = 512,
  parameter int MAX_PTR = 6,
  localparam int IW = $clog2(BLK_W),
  localparam int CW = $clog2(MAX_PTR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       fail_type_i,
  input  logic             rd_valid_i,
  input  logic             rd_ce_i,
  input  logic [IW-1:0]    rd_err_idx_i,
  input  logic [BLK_W-1:0] rd_data_i,
  input  logic [BLK_W-1:0] arr_mask_i,
  input  logic [CW-1:0]    ptr_used_i,
  output logic             rsp_valid_o,
  output logic [BLK_W-1:0] rsp_data_o,
  output logic             rr_valid_o,
  input  logic             rr_ready_i,
  output logic [IW-1:0]    rr_idx_o,
  output logic [1:0]       rr_ref_o,
  input  logic             rr_res_valid_i,
  input  logic             rr_res_above_i,
  output logic             mark_valid_o,
  output logic [IW-1:0]    mark_idx_o,
  output logic             rst_pulse_o,
  output logic [IW-1:0]    rst_idx_o,
  output logic             retired_o,
  output logic             done_o,
  output logic             done_hard_o
);
  cls_state_t       state_q;
  wear_model_t      model_q, model_in;
  logic [IW-1:0]    pos_q, cur_q;
  logic             exp1_q, found_q, hard_q, do_rst_q;
  logic [BLK_W-1:0] pend_q;
  logic             scan_hit;
  logic [IW-1:0]    scan_idx;
  logic             start, full;

  assign start    = (state_q == S_IDLE) && rd_valid_i && rd_ce_i;
  assign model_in = (fail_type_i == 2'd3) ? FT_C : wear_model_t'(fail_type_i);

  hec_rsp_reg #(.W(BLK_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (rd_valid_i),
    .in_data_i   (rd_data_i),
    .out_valid_o (rsp_valid_o),
    .out_data_o  (rsp_data_o)
  );

  hec_first_one #(.W(BLK_W)) u_seek (
    .vec_i   (pend_q),
    .found_o (scan_hit),
    .idx_o   (scan_idx)
  );

  hec_ptr_budget #(.MAX_PTR(MAX_PTR)) u_budget (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (ptr_used_i),
    .use_i      (mark_valid_o),
    .full_o     (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      model_q  <= FT_A;
      pos_q    <= '0;
      cur_q    <= '0;
      exp1_q   <= 1'b0;
      found_q  <= 1'b0;
      hard_q   <= 1'b0;
      do_rst_q <= 1'b0;
      pend_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            model_q  <= model_in;
            pos_q    <= rd_err_idx_i;
            cur_q    <= rd_err_idx_i;
            exp1_q   <= rd_data_i[rd_err_idx_i];
            found_q  <= 1'b0;
            hard_q   <= 1'b0;
            do_rst_q <= 1'b0;
            pend_q   <= '0;
            if (model_in == FT_B) begin
              pend_q  <= rd_data_i & arr_mask_i;
              state_q <= S_SCAN;
            end else if (!rd_data_i[rd_err_idx_i]) begin
              // flip 0->1 cannot be a retention upset
              hard_q  <= 1'b1;
              state_q <= S_MARK;
            end else if (model_in == FT_A) begin
              state_q <= S_REQ;
            end else begin
              state_q <= S_DONE;
            end
          end
        end
        S_SCAN: begin
          if (scan_hit) begin
            cur_q            <= scan_idx;
            pend_q[scan_idx] <= 1'b0;
            state_q          <= S_REQ;
          end else if (found_q) begin
            hard_q  <= 1'b1;
            state_q <= S_DONE;
          end else if (!exp1_q) begin
            cur_q    <= pos_q;
            hard_q   <= 1'b1;
            do_rst_q <= 1'b0;
            state_q  <= S_MARK;
          end else begin
            state_q <= S_DONE;
          end
        end
        S_REQ: begin
          if (rr_ready_i) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (rr_res_valid_i) begin
            if (rr_res_above_i) begin
              hard_q   <= 1'b1;
              found_q  <= 1'b1;
              do_rst_q <= (model_q == FT_B);
              state_q  <= S_MARK;
            end else begin
              state_q <= (model_q == FT_B) ? S_SCAN : S_DONE;
            end
          end
        end
        S_MARK: begin
          if (full)          state_q <= do_rst_q ? S_SCAN : S_DONE;
          else if (do_rst_q) state_q <= S_RST;
          else               state_q <= S_DONE;
        end
        S_RST:   state_q <= S_SCAN;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rr_valid_o   = (state_q == S_REQ);
  assign rr_idx_o     = cur_q;
  assign rr_ref_o     = (model_q == FT_B) ? REF_HIGH : REF_LOW;
  assign mark_valid_o = (state_q == S_MARK) && !full;
  assign retired_o    = (state_q == S_MARK) && full;
  assign mark_idx_o   = cur_q;
  assign rst_pulse_o  = (state_q == S_RST);
  assign rst_idx_o    = cur_q;
  assign done_o       = (state_q == S_DONE);
  assign done_hard_o  = done_o && hard_q;

  // R1
  rsp_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> (rsp_valid_o && rsp_data_o == $past(rd_data_i)));

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_valid_o && !rr_ready_i) |=> (rr_valid_o && $stable(rr_idx_o)));

  // R7
  rst_after_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pulse_o) |-> ($past(mark_valid_o) && rst_idx_o == $past(mark_idx_o)));

  // R9
  mark_retire_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mark_valid_o && retired_o));

  // R2
  one_action_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rr_valid_o, mark_valid_o, retired_o, rst_pulse_o, done_o}));
endmodule

// File: tb/hard_err_classifier_bench.sv
`timescale 1ns/1ps
module hard_err_classifier_bench;
  localparam int W  = 512;
  localparam int IW = 9;

  localparam int K_RRL = 1, K_RRH = 2, K_MARK = 3, K_RST = 4, K_RET = 5,
                 K_DSOFT = 6, K_DHARD = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    fail_type;
  logic          rd_valid, rd_ce;
  logic [IW-1:0] rd_idx;
  logic [W-1:0]  rd_data, arr_mask;
  logic [2:0]    ptr_used;
  logic          rsp_valid;
  logic [W-1:0]  rsp_data;
  logic          rr_valid, rr_ready, rr_res_valid, rr_res_above;
  logic [IW-1:0] rr_idx, mark_idx, rst_idx;
  logic [1:0]    rr_ref;
  logic          mark_valid, rst_pulse, retired, done, done_hard;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int done_cyc = 0;
  int exp_q[$];
  string tag_q[$];
  bit [W-1:0] weak_v = '0;
  int stall_cfg = 0;
  int stall_left = 0;
  bit res_pend = 1'b0;
  bit res_above = 1'b0;

  always #2 clk = ~clk;

  hard_err_classifier u_hard_err_classifier (
    .clk_i(clk), .rst_ni(rst_n), .fail_type_i(fail_type),
    .rd_valid_i(rd_valid), .rd_ce_i(rd_ce), .rd_err_idx_i(rd_idx),
    .rd_data_i(rd_data), .arr_mask_i(arr_mask), .ptr_used_i(ptr_used),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rr_valid_o(rr_valid), .rr_ready_i(rr_ready), .rr_idx_o(rr_idx),
    .rr_ref_o(rr_ref), .rr_res_valid_i(rr_res_valid), .rr_res_above_i(rr_res_above),
    .mark_valid_o(mark_valid), .mark_idx_o(mark_idx),
    .rst_pulse_o(rst_pulse), .rst_idx_o(rst_idx), .retired_o(retired),
    .done_o(done), .done_hard_o(done_hard)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int kind, input int idx, input string tag);
    exp_q.push_back(kind * 1024 + idx);
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // comparator model: stalls ready, returns one result beat per accepted request
  initial begin
    rr_ready = 1'b0; rr_res_valid = 1'b0; rr_res_above = 1'b0;
    forever begin
      @(negedge clk);
      rr_res_valid = res_pend;
      rr_res_above = res_above;
      res_pend = 1'b0;
      if (rr_valid && !rr_ready) begin
        if (stall_left > 0) begin
          stall_left--;
        end else begin
          rr_ready = 1'b1;
          res_pend = 1'b1;
          res_above = weak_v[rr_idx];
        end
      end else begin
        rr_ready = 1'b0;
        stall_left = stall_cfg;
      end
    end
  end

  // monitor: pops the scoreboard as events appear
  initial forever begin
    int ev;
    @(negedge clk);
    #1;
    ev = -1;
    if (rst_n) begin
      if (rr_valid && rr_ready)
        ev = ((rr_ref == 2'b10) ? K_RRH : (rr_ref == 2'b01) ? K_RRL : 0) * 1024 + int'(rr_idx);
      else if (mark_valid) ev = K_MARK * 1024 + int'(mark_idx);
      else if (retired)    ev = K_RET * 1024 + int'(mark_idx);
      else if (rst_pulse)  ev = K_RST * 1024 + int'(rst_idx);
      else if (done) begin
        ev = (done_hard ? K_DHARD : K_DSOFT) * 1024;
        done_cyc = cyc;
      end
      if (ev >= 0) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected event", ev, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(ev == e, t, ev, e);
        end
      end
    end
  end

  task automatic mark_or_ret(inout int cnt, input int idx, input bit with_rst);
    if (cnt >= 6) begin
      push(K_RET, idx, "R9 retire");
    end else begin
      push(K_MARK, idx, "R3/R5/R7/R8 mark");
      if (with_rst) push(K_RST, idx, "R7 reset pulse");
      cnt++;
    end
  endtask

  task automatic run_case(input logic [1:0] ft, input int pos, input logic [W-1:0] data,
                          input logic [W-1:0] mask, input int used, input int stall,
                          input int lat, input bit inject, input string name);
    int cnt;
    int start;
    int guard;
    bit found;
    bit e1;
    cnt = used;
    e1 = data[pos];
    stall_cfg = stall;
    if (ft == 2'd1) begin
      found = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (data[i] && mask[i]) begin
          push(K_RRH, i, "R6 scan re-read");
          if (weak_v[i]) begin
            found = 1'b1;
            mark_or_ret(cnt, i, 1'b1);
          end
        end
      end
      if (found) push(K_DHARD, 0, "R7 hard done");
      else if (!e1) begin
        mark_or_ret(cnt, pos, 1'b0);
        push(K_DHARD, 0, "R8 hard done");
      end else push(K_DSOFT, 0, "R8 soft done");
    end else if (!e1) begin
      mark_or_ret(cnt, pos, 1'b0);
      push(K_DHARD, 0, "R3 hard done");
    end else if (ft == 2'd0) begin
      push(K_RRL, pos, "R5 low re-read");
      if (weak_v[pos]) begin
        mark_or_ret(cnt, pos, 1'b0);
        push(K_DHARD, 0, "R5 hard done");
      end else push(K_DSOFT, 0, "R5 soft done");
    end else begin
      push(K_DSOFT, 0, "R4 soft done");
    end

    @(negedge clk);
    fail_type = ft; rd_valid = 1'b1; rd_ce = 1'b1; rd_idx = IW'(pos);
    rd_data = data; arr_mask = mask; ptr_used = 3'(used);
    start = cyc;
    @(negedge clk);
    rd_valid = 1'b0; rd_ce = 1'b0;
    chk(rsp_valid && rsp_data == data, {"R1 response ", name}, rsp_valid, 1);
    if (inject) begin
      @(negedge clk);
      rd_valid = 1'b1; rd_ce = 1'b1; fail_type = 2'd2; rd_idx = 9'd77;
      rd_data = '0; ptr_used = 3'd0;
      @(negedge clk);
      rd_valid = 1'b0; rd_ce = 1'b0;
      chk(rsp_valid && rsp_data == '0, "R1 response while busy", rsp_valid, 1);
    end
    guard = 0;
    while (exp_q.size() > 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(exp_q.size() == 0, {"R2 pending events ", name}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    if (lat >= 0) chk(done_cyc - start == lat, {"R3/R4 done latency ", name}, done_cyc - start, lat);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] d, m;
    fail_type = 2'd0; rd_valid = 1'b0; rd_ce = 1'b0; rd_idx = '0;
    rd_data = '0; arr_mask = '0; ptr_used = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !rr_valid && !mark_valid && !rst_pulse && !retired && !done,
        "R10 reset outputs idle", {rsp_valid, rr_valid, mark_valid, rst_pulse, retired, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // model A, flip 0->1
    d = '1; d[37] = 1'b0;
    run_case(2'd0, 37, d, '0, 0, 0, 2, 1'b0, "A up");
    // model C, flip 0->1
    d = '0; d[3] = 1'b1;
    run_case(2'd2, 500, d, '0, 2, 0, 2, 1'b0, "C up");
    // model C, flip 1->0: soft
    d = '0; d[5] = 1'b1;
    run_case(2'd2, 5, d, '0, 0, 0, 1, 1'b0, "C down");
    // value 3 behaves as C
    run_case(2'd3, 5, d, '0, 0, 0, 1, 1'b0, "R4 type3");
    // model A, flip 1->0, weak cell, stalled ready
    weak_v = '0; weak_v[5] = 1'b1;
    run_case(2'd0, 5, d, '0, 1, 2, -1, 1'b0, "A down weak");
    // model A, flip 1->0, healthy cell
    weak_v = '0;
    run_case(2'd0, 5, d, '0, 1, 0, -1, 1'b0, "A down soft");

    // model B scan with two weak cells
    d = '0; d[3] = 1; d[10] = 1; d[40] = 1; d[41] = 1; d[200] = 1; d[300] = 1;
    m = '0; m[3] = 1; m[10] = 1; m[40] = 1; m[200] = 1; m[511] = 1;
    weak_v = '0; weak_v[10] = 1; weak_v[200] = 1; weak_v[41] = 1;
    run_case(2'd1, 10, d, m, 0, 1, -1, 1'b0, "B scan");
    // model B, budget runs out mid-scan
    run_case(2'd1, 10, d, m, 5, 0, -1, 1'b0, "R9 B budget");
    // model B, no weak cell, flip 0->1
    weak_v = '0;
    run_case(2'd1, 511, d, m, 0, 0, -1, 1'b0, "R8 B up");
    // model B, no weak cell, flip 1->0
    run_case(2'd1, 40, d, m, 0, 0, -1, 1'b0, "R8 B down");
    // model A, no pointers left
    d = '1; d[9] = 1'b0;
    run_case(2'd0, 9, d, '0, 6, 0, 2, 1'b0, "R9 A full");

    // R2: report during a running classification is ignored
    d = '0; d[20] = 1'b1;
    run_case(2'd0, 20, d, '0, 0, 6, -1, 1'b1, "R2 busy");

    // R2: read without error flag starts nothing
    @(negedge clk);
    rd_valid = 1'b1; rd_ce = 1'b0; fail_type = 2'd2; rd_data = '0; rd_idx = 9'd1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(rsp_valid && rsp_data == '0, "R1 clean read response", rsp_valid, 1);
    repeat (5) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule